// File: doc/BRIEF.md
# Bus-Shareable General Purpose I/O Port

This block is an eight-pin general purpose I/O port with two registers on a simple register bus: an output value register and a direction register. Each pin is driven from the output value register when its direction bit is set. When its direction bit is clear, the pin is a high-impedance input, and its level passes through a synchronizer before software reads it.

The low seven pins can be taken over by an external memory bus. In the expanded operating modes those pins carry high-order address bits. In emulation mode they alternate between address bits and bus status signals, selected by a phase input. A takeover never rewrites the direction register, so the software setting comes back when the port returns to a non-expanded mode.

In emulation mode the register bus is mirrored onto an external bus interface. Register reads return the data captured from that bus. Register writes update the local register and are also presented to the external bus in the same cycle.

Top module: `gpio_busport`

## Requirements
- R1: After reset, both registers read as 0x00, every output enable is 0 and the port is in single-chip mode.
- R2: In a mode where a pin is general purpose, its output enable equals its direction bit and its output equals its stored value bit. Register writes are captured on the rising edge where `reg_wr_i` is high and are visible from the following cycle.
- R3: A read of the value register (`reg_addr_i`=0) returns the stored bit for each general purpose pin with direction 1. For every other pin it returns the pin input delayed by two clock edges.
- R4: A read of the direction register (`reg_addr_i`=1) returns the stored direction bits outside emulation mode.
- R5: `mode_i` encodes 00 single-chip, 01 normal expanded, 10 emulation, 11 special. It is registered, so a change of mode alters pin ownership only after the next rising edge. Special mode behaves like single-chip.
- R6: In modes 01 and 10, pins 6..0 have their output enable forced to 1 and output `alt_addr_i` (emulation with phase 0 included). Pin 7 stays general purpose.
- R7: In emulation mode, pins 6..0 output `alt_stat_i` while `alt_phase_i` is 1 and `alt_addr_i` while it is 0.
- R8: Bus takeover leaves both registers unchanged. On return to single-chip mode, the output enables again equal the stored direction bits.
- R9: In emulation mode, a read of either register returns `ext_rdata_i`, and `ext_rd_o` follows `reg_rd_i`.
- R10: In emulation mode, a write raises `ext_wr_o` in the same cycle, with `ext_addr_o` and `ext_wdata_o` equal to the register address and data, and it also updates the local register. Outside emulation mode `ext_wr_o` and `ext_rd_o` stay 0.
- R11: In normal expanded mode, a value register read returns the synchronized pin input for pins 6..0 whatever their direction bits.
- R12: `reg_rdata_o` is 0x00 whenever `reg_rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode code |
| reg_addr_i | input | 1 | Register select: 0 value, 1 direction |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| pin_in_i | input | 8 | Pad input levels |
| pin_out_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| alt_addr_i | input | 7 | High address bits from the external bus engine |
| alt_stat_i | input | 7 | Status signals shared with the address pins in emulation |
| alt_phase_i | input | 1 | Emulation multiplex phase: 1 selects status |
| ext_rdata_i | input | 8 | Data captured from the external bus |
| ext_rd_o | output | 1 | Read forwarded to the external bus |
| ext_wr_o | output | 1 | Write forwarded to the external bus |
| ext_addr_o | output | 1 | Register select forwarded to the external bus |
| ext_wdata_o | output | 8 | Write data forwarded to the external bus |

## Verification
The assertions assume that `mode_i` and the register strobes are synchronous to `clk` and are stable around the rising edge. They also assume that a mode reaches the port only through its registered copy, so every property that depends on ownership looks at the mode one cycle back. The bench changes every input on the falling edge and samples results just after it. The bench never drives read and write together, and it leaves one cycle after each mode change before it checks ownership, so the stimulus stays within those assumptions.

// File: rtl/gpio_busport_pkg.sv
package gpio_busport_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'b00,
    MODE_NEXP    = 2'b01,
    MODE_EMUL    = 2'b10,
    MODE_SPECIAL = 2'b11
  } mode_e;

  localparam logic SEL_VALUE = 1'b0;
  localparam logic SEL_DIR   = 1'b1;
endpackage

// File: rtl/gpio_busport_sync.sv
module gpio_busport_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_d;

  always_comb begin
    st_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) st_d[s] = st_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_busport_regs.sv
module gpio_busport_regs
  import gpio_busport_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] value_o,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] value_q, value_d;
  logic [W-1:0] dir_q, dir_d;
  logic         value_en, dir_en;

  assign value_en = wr_i && (sel_i == SEL_VALUE);
  assign dir_en   = wr_i && (sel_i == SEL_DIR);

  always_comb begin
    value_d = value_q;
    dir_d   = dir_q;
    if (value_en) value_d = wdata_i;
    if (dir_en)   dir_d   = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      dir_q   <= '0;
    end else begin
      value_q <= value_d;
      dir_q   <= dir_d;
    end
  end

  assign value_o = value_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/gpio_busport_pinmux.sv
module gpio_busport_pinmux #(
  parameter int unsigned W        = 8,
  parameter int unsigned BUS_PINS = 7
) (
  input  logic [W-1:0]        own_i,
  input  logic                emul_i,
  input  logic                phase_i,
  input  logic [BUS_PINS-1:0] alt_addr_i,
  input  logic [BUS_PINS-1:0] alt_stat_i,
  input  logic [W-1:0]        value_i,
  input  logic [W-1:0]        dir_i,
  output logic [W-1:0]        out_o,
  output logic [W-1:0]        oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i < BUS_PINS) begin : g_shared
      logic alt_bit;
      assign alt_bit = (emul_i && phase_i) ? alt_stat_i[i] : alt_addr_i[i];
      assign out_o[i] = own_i[i] ? alt_bit : value_i[i];
      assign oe_o[i]  = own_i[i] | dir_i[i];
    end else begin : g_plain
      assign out_o[i] = value_i[i];
      assign oe_o[i]  = dir_i[i];
    end
  end
endmodule

// File: rtl/gpio_busport.sv
module gpio_busport
  import gpio_busport_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned BUS_PINS    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                reg_addr_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [W-1:0]        reg_wdata_i,
  output logic [W-1:0]        reg_rdata_o,
  input  logic [W-1:0]        pin_in_i,
  output logic [W-1:0]        pin_out_o,
  output logic [W-1:0]        pin_oe_o,
  input  logic [BUS_PINS-1:0] alt_addr_i,
  input  logic [BUS_PINS-1:0] alt_stat_i,
  input  logic                alt_phase_i,
  input  logic [W-1:0]        ext_rdata_i,
  output logic                ext_rd_o,
  output logic                ext_wr_o,
  output logic                ext_addr_o,
  output logic [W-1:0]        ext_wdata_o
);
  localparam logic [W-1:0] BUS_MASK = {{(W-BUS_PINS){1'b0}}, {BUS_PINS{1'b1}}};

  mode_e        mode_q, mode_d;
  logic         expanded, emul;
  logic [W-1:0] own;
  logic [W-1:0] value_q, dir_q, pin_sync;
  logic [W-1:0] local_rd;

  always_comb mode_d = mode_e'(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SINGLE;
    else        mode_q <= mode_d;
  end

  assign emul     = (mode_q == MODE_EMUL);
  assign expanded = (mode_q == MODE_NEXP) || emul;
  assign own      = expanded ? BUS_MASK : '0;

  gpio_busport_regs #(.W(W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .value_o (value_q),
    .dir_o   (dir_q)
  );

  gpio_busport_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in_i),
    .q_o   (pin_sync)
  );

  gpio_busport_pinmux #(.W(W), .BUS_PINS(BUS_PINS)) pinmux_i (
    .own_i      (own),
    .emul_i     (emul),
    .phase_i    (alt_phase_i),
    .alt_addr_i (alt_addr_i),
    .alt_stat_i (alt_stat_i),
    .value_i    (value_q),
    .dir_i      (dir_q),
    .out_o      (pin_out_o),
    .oe_o       (pin_oe_o)
  );

  always_comb begin
    local_rd = dir_q;
    if (reg_addr_i == SEL_VALUE) begin
      for (int b = 0; b < W; b++)
        local_rd[b] = (dir_q[b] && !own[b]) ? value_q[b] : pin_sync[b];
    end
  end

  always_comb begin
    if (!reg_rd_i)  reg_rdata_o = '0;
    else if (emul)  reg_rdata_o = ext_rdata_i;
    else            reg_rdata_o = local_rd;
  end

  assign ext_rd_o    = emul && reg_rd_i;
  assign ext_wr_o    = emul && reg_wr_i;
  assign ext_addr_o  = reg_addr_i;
  assign ext_wdata_o = reg_wdata_i;
endmodule

// File: rtl/gpio_busport_chk.sv
module gpio_busport_chk #(
  parameter int unsigned W        = 8,
  parameter int unsigned BUS_PINS = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_i,
  input logic         reg_addr_i,
  input logic         reg_wr_i,
  input logic         reg_rd_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] reg_rdata_o,
  input logic [W-1:0] pin_oe_o,
  input logic [W-1:0] ext_rdata_i,
  input logic         ext_wr_o,
  input logic [W-1:0] ext_wdata_o
);
  logic valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |-> reg_rdata_o == '0);

  p_bus_owns_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ($past(mode_i) == 2'b01 || $past(mode_i) == 2'b10))
      |-> &pin_oe_o[BUS_PINS-1:0]);

  p_emul_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(mode_i) == 2'b10 && reg_rd_i) |-> reg_rdata_o == ext_rdata_i);

  p_fwd_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_o |-> (reg_wr_i && ext_wdata_o == reg_wdata_i));

  p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(reg_wr_i && reg_addr_i && mode_i == 2'b00))
      |-> pin_oe_o == $past(reg_wdata_i));
endmodule

bind gpio_busport gpio_busport_chk #(.W(W), .BUS_PINS(BUS_PINS)) chk_i (.*);

// File: tb/gpio_busport_tb_top.sv
`timescale 1ns/1ps
module gpio_busport_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       reg_addr_i, reg_wr_i, reg_rd_i;
  logic [7:0] reg_wdata_i, reg_rdata_o;
  logic [7:0] pin_in_i, pin_out_o, pin_oe_o;
  logic [6:0] alt_addr_i, alt_stat_i;
  logic       alt_phase_i;
  logic [7:0] ext_rdata_i;
  logic       ext_rd_o, ext_wr_o, ext_addr_o;
  logic [7:0] ext_wdata_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gpio_busport dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] v);
    @(negedge clk);
    reg_addr_i = sel; reg_wdata_i = v; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] v);
    @(negedge clk);
    reg_addr_i = sel; reg_rd_i = 1'b1;
    #1 v = reg_rdata_o;
    reg_rd_i = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_i = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1 check("R1 oe", pin_oe_o, 8'h00);
    rd_reg(1'b1, v); check("R1 dir", v, 8'h00);
    rd_reg(1'b0, v); check("R1 value", v, 8'h00);
    check("R1 ext_rd", {7'd0, ext_rd_o}, 8'h00);
  endtask

  task automatic t_gpio();
    logic [7:0] v;
    wr_reg(1'b0, 8'hA5);
    wr_reg(1'b1, 8'h0F);
    #1 check("R2 oe", pin_oe_o, 8'h0F);
    check("R2 out", pin_out_o, 8'hA5);
    rd_reg(1'b1, v); check("R4 dir read", v, 8'h0F);
    @(negedge clk); pin_in_i = 8'h3C;
    repeat (2) @(negedge clk);
    rd_reg(1'b0, v); check("R3 mixed read", v, 8'h35);
    pin_in_i = 8'hFF;
    @(negedge clk);
    reg_addr_i = 1'b0; reg_rd_i = 1'b1;
    #1 check("R3 one edge", reg_rdata_o, 8'h35);
    reg_rd_i = 1'b0;
    @(negedge clk);
    reg_rd_i = 1'b1;
    #1 check("R3 two edges", reg_rdata_o, 8'hF5);
    reg_rd_i = 1'b0;
    #0.1 check("R12 idle", reg_rdata_o, 8'h00);
  endtask

  task automatic t_expanded();
    logic [7:0] v;
    alt_addr_i = 7'h55; alt_stat_i = 7'h2A; alt_phase_i = 1'b1;
    @(negedge clk); mode_i = 2'b01;
    #1 check("R5 not yet", pin_oe_o, 8'h0F);
    @(negedge clk);
    #1 check("R6 oe", pin_oe_o, 8'h7F);
    check("R6 out", pin_out_o, 8'hD5);
    pin_in_i = 8'h00;
    repeat (3) @(negedge clk);
    rd_reg(1'b0, v); check("R11 owned read", v, 8'h00);
    check("R10 no ext_rd", {7'd0, ext_rd_o}, 8'h00);
    set_mode(2'b00);
    #1 check("R8 oe restored", pin_oe_o, 8'h0F);
    rd_reg(1'b1, v); check("R8 dir kept", v, 8'h0F);
    rd_reg(1'b0, v); check("R8 value kept", v, 8'h05);
  endtask

  task automatic t_emul();
    logic [7:0] v;
    ext_rdata_i = 8'h9C;
    set_mode(2'b10);
    alt_phase_i = 1'b1;
    #1 check("R7 status", pin_out_o, 8'hAA);
    alt_phase_i = 1'b0;
    #1 check("R7 addr", pin_out_o, 8'hD5);
    check("R6 emul oe", pin_oe_o, 8'h7F);
    @(negedge clk);
    reg_addr_i = 1'b0; reg_rd_i = 1'b1;
    #1 check("R9 value", reg_rdata_o, 8'h9C);
    check("R9 ext_rd", {7'd0, ext_rd_o}, 8'h01);
    reg_addr_i = 1'b1;
    #1 check("R9 dir", reg_rdata_o, 8'h9C);
    reg_rd_i = 1'b0;
    @(negedge clk);
    reg_addr_i = 1'b1; reg_wdata_i = 8'h3C; reg_wr_i = 1'b1;
    #1 check("R10 ext_wr", {7'd0, ext_wr_o}, 8'h01);
    check("R10 ext_wdata", ext_wdata_o, 8'h3C);
    check("R10 ext_addr", {7'd0, ext_addr_o}, 8'h01);
    @(negedge clk); reg_wr_i = 1'b0;
    set_mode(2'b00);
    #1 check("R10 local update", pin_oe_o, 8'h3C);
    reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 8'h05;
    #1 check("R10 no fwd", {7'd0, ext_wr_o}, 8'h00);
    @(negedge clk); reg_wr_i = 1'b0;
  endtask

  task automatic t_special();
    logic [7:0] v;
    set_mode(2'b11);
    #1 check("R5 special oe", pin_oe_o, 8'h3C);
    check("R5 special out", pin_out_o, 8'h05);
    rd_reg(1'b1, v); check("R5 special dir", v, 8'h3C);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'b00; reg_addr_i = 1'b0; reg_wr_i = 1'b0; reg_rd_i = 1'b0;
    reg_wdata_i = 8'h00; pin_in_i = 8'h00; alt_addr_i = 7'h00; alt_stat_i = 7'h00;
    alt_phase_i = 1'b0; ext_rdata_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gpio();
    t_expanded();
    t_emul();
    t_special();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule